// File: doc/BRIEF.md
# Level-Tracking Interrupt Aggregator

This block gathers a set of level-sensitive interrupt request lines (32 by default) into one interrupt output for a processor. Each clock it samples every line into a pending vector, which simply mirrors the line levels. An enable vector masks the pending vector. The output interrupt is raised whenever any enabled line is pending.

Software reaches the block through a simple 32-bit register bus with byte addresses and word-sized accesses. It can read how many enabled lines are active, or read the masked pending vector itself. It can set enable bits and clear enable bits through separate write-one registers. A single command wipes both the enable and pending vectors.

A bank of per-line event counters, chosen by a parameter, counts rising transitions of each sampled line. A side port selects one counter and reads it out.

Top module: `irq_aggregator`

## Requirements
- R1: The register map uses aligned byte offsets: 0x00 active count (read), 0x04 masked pending vector (read), 0x08 wipe command (write), 0x0C enable clear mask (write), 0x10 enable set mask (write).
- R2: A read at 0x00 returns the number of set bits in pending AND enable, a value from 0 to 32, in the low bits, with zeros above.
- R3: A read at 0x04 returns pending AND enable, never the raw pending vector.
- R4: A write to 0x08 clears both the enable vector and the pending vector at the next clock edge, whatever the write data.
- R5: A write to 0x10 sets each enable bit whose data bit is 1, and a write to 0x0C clears each enable bit whose data bit is 1. All other enable bits keep their value.
- R6: Each pending bit takes the level of its input line at every clock edge, so a line driven low drops its pending bit.
- R7: `irq_out` is high exactly when pending AND enable is nonzero. It changes at the same clock edge as the state that causes it.
- R8: Reset clears pending, enable, `irq_out` and every event counter.
- R9: Reads at any other offset, including misaligned offsets and the write-only offsets, return 0. Writes to any other offset, including misaligned offsets and the read-only offsets, change nothing.
- R10: The counter of a line increments once for each clock edge at which the line is sampled high after being sampled low. A line held high counts once. `stat_count` shows the counter chosen by `stat_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_LINES | Level-sensitive interrupt request lines |
| bus_valid | input | 1 | Access strobe for the current cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read strobe, 0 otherwise |
| irq_out | output | 1 | Combined interrupt to the processor |
| stat_sel | input | SEL_W | Line whose event counter is shown |
| stat_count | output | CNT_W | Event counter of the selected line |

## Verification
First, each line is driven and enabled on its own, one at a time. This shows that every bit position reaches the right place in the masked vector and the count, and that masking and unmasking each bit switches the output. Next, a long run of computed pseudo-random line patterns is combined with mixed set and clear masks. These show that the count equals the population of the masked vector, and that the raw pending bits of disabled lines never leak into reads. Finally, reads and writes to unmapped, misaligned and opposite-direction offsets check that they have no effect. A wipe under active enabled lines, short pulses against a held line on the counters, and a reset in the middle of activity cover R4, R8 and R10.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned OFS_COUNT   = 32'h00;
  localparam int unsigned OFS_MASKED  = 32'h04;
  localparam int unsigned OFS_WIPE    = 32'h08;
  localparam int unsigned OFS_EN_CLR  = 32'h0C;
  localparam int unsigned OFS_EN_SET  = 32'h10;

  typedef enum logic [1:0] {
    WCMD_NONE   = 2'd0,
    WCMD_WIPE   = 2'd1,
    WCMD_EN_CLR = 2'd2,
    WCMD_EN_SET = 2'd3
  } wcmd_e;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_COUNT  = 2'd1,
    RSEL_MASKED = 2'd2
  } rsel_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output wcmd_e             wcmd,
  output rsel_e             rsel
);
  logic hit_count, hit_masked, hit_wipe, hit_clr, hit_set;

  assign hit_count  = (bus_addr == ADDR_W'(OFS_COUNT));
  assign hit_masked = (bus_addr == ADDR_W'(OFS_MASKED));
  assign hit_wipe   = (bus_addr == ADDR_W'(OFS_WIPE));
  assign hit_clr    = (bus_addr == ADDR_W'(OFS_EN_CLR));
  assign hit_set    = (bus_addr == ADDR_W'(OFS_EN_SET));

  always_comb begin
    wcmd = WCMD_NONE;
    if (bus_valid && bus_write) begin
      if (hit_wipe)     wcmd = WCMD_WIPE;
      else if (hit_clr) wcmd = WCMD_EN_CLR;
      else if (hit_set) wcmd = WCMD_EN_SET;
    end
  end

  always_comb begin
    rsel = RSEL_NONE;
    if (bus_valid && !bus_write) begin
      if (hit_count)       rsel = RSEL_COUNT;
      else if (hit_masked) rsel = RSEL_MASKED;
    end
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_in,
  input  wcmd_e                wcmd,
  input  logic [NUM_LINES-1:0] wmask,
  output logic [NUM_LINES-1:0] pending_q,
  output logic [NUM_LINES-1:0] enable_q,
  output logic                 irq_q
);
  logic [NUM_LINES-1:0] pending_d, enable_d;
  logic                 enable_ce;
  logic                 irq_d;

  always_comb begin
    pending_d = lines_in;
    enable_d  = enable_q;
    enable_ce = 1'b0;
    unique case (wcmd)
      WCMD_WIPE: begin
        pending_d = '0;
        enable_d  = '0;
        enable_ce = 1'b1;
      end
      WCMD_EN_CLR: begin
        enable_d  = enable_q & ~wmask;
        enable_ce = 1'b1;
      end
      WCMD_EN_SET: begin
        enable_d  = enable_q | wmask;
        enable_ce = 1'b1;
      end
      default: ;
    endcase
    irq_d = |(pending_d & enable_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      irq_q     <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (enable_ce) begin
      enable_q <= enable_d;
    end
  end
endmodule

// File: rtl/irq_popcount.sv
module irq_popcount #(
  parameter int NUM_LINES = 32,
  parameter int COUNT_W   = $clog2(NUM_LINES + 1)
) (
  input  logic [NUM_LINES-1:0] vec,
  output logic [COUNT_W-1:0]   ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      ones = ones + COUNT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/irq_event_counters.sv
module irq_event_counters #(
  parameter int NUM_LINES = 32,
  parameter int CNT_W     = 16,
  parameter int SEL_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_in,
  input  logic [SEL_W-1:0]     sel,
  output logic [CNT_W-1:0]     count
);
  logic [NUM_LINES-1:0] prev_q;
  logic [CNT_W-1:0]     cnt_arr [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines_in;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic             bump;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign bump = lines_in[i] & ~prev_q[i];

    always_comb cnt_d = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (bump) cnt_q <= cnt_d;
    end

    assign cnt_arr[i] = cnt_q;
  end

  always_comb begin
    count = '0;
    if (32'(sel) < NUM_LINES) count = cnt_arr[sel];
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 16,
  parameter bit STATS_EN  = 1'b1,
  localparam int SEL_W    = $clog2(NUM_LINES),
  localparam int COUNT_W  = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_out,
  input  logic [SEL_W-1:0]     stat_sel,
  output logic [CNT_W-1:0]     stat_count
);
  logic [1:0]           rst_sync_q;
  logic                 rst_n_int;
  wcmd_e                wcmd;
  rsel_e                rsel;
  logic [NUM_LINES-1:0] pending_w, enable_w, active_w;
  logic [COUNT_W-1:0]   active_ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .wcmd      (wcmd),
    .rsel      (rsel)
  );

  irq_state_regs #(.NUM_LINES(NUM_LINES)) u_state (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .lines_in  (irq_in),
    .wcmd      (wcmd),
    .wmask     (bus_wdata[NUM_LINES-1:0]),
    .pending_q (pending_w),
    .enable_q  (enable_w),
    .irq_q     (irq_out)
  );

  assign active_w = pending_w & enable_w;

  irq_popcount #(.NUM_LINES(NUM_LINES), .COUNT_W(COUNT_W)) u_pop (
    .vec  (active_w),
    .ones (active_ones)
  );

  always_comb begin
    unique case (rsel)
      RSEL_COUNT:  bus_rdata = DATA_W'(active_ones);
      RSEL_MASKED: bus_rdata = DATA_W'(active_w);
      default:     bus_rdata = '0;
    endcase
  end

  if (STATS_EN) begin : g_stats
    irq_event_counters #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .lines_in (irq_in),
      .sel      (stat_sel),
      .count    (stat_count)
    );
  end else begin : g_no_stats
    assign stat_count = '0;
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rst_n_int,
  input logic [NUM_LINES-1:0] irq_in,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 irq_out,
  input logic [NUM_LINES-1:0] pending_w,
  input logic [NUM_LINES-1:0] enable_w
);
  logic wr_wipe, wr_set, wr_clr, rd_count, rd_other;

  assign wr_wipe  = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h08));
  assign wr_clr   = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h0C));
  assign wr_set   = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h10));
  assign rd_count = bus_valid && !bus_write && (bus_addr == ADDR_W'(8'h00));
  assign rd_other = bus_valid && !bus_write && (bus_addr != ADDR_W'(8'h00))
                    && (bus_addr != ADDR_W'(8'h04));

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_wipe |=> (pending_w == '0) && (enable_w == '0) && !irq_out);   // R4

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_set |=> ((enable_w & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0]))); // R5

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_clr |=> ((enable_w & $past(bus_wdata[NUM_LINES-1:0])) == '0)); // R5

  AST_PENDING_TRACKS: assert property (@(posedge clk) disable iff (!rst_n_int)
    !wr_wipe |=> (pending_w == $past(irq_in)));   // R6

  AST_IRQ_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_count |-> ((bus_rdata != '0) == irq_out));   // R7

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_other |-> (bus_rdata == '0));   // R9
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .irq_in    (irq_in),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .pending_w (pending_w),
  .enable_w  (enable_w)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        bus_valid, bus_write;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_out;
  logic [4:0]  stat_sel;
  logic [15:0] stat_count;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .stat_sel(stat_sel), .stat_count(stat_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_wdata = '0;
  endtask

  task automatic do_read(input logic [5:0] a, output logic [31:0] d, output logic irq);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #2;
    d = bus_rdata; irq = irq_out;
    bus_valid = 0;
  endtask

  task automatic set_lines(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic read_cnt(input int line, output logic [15:0] c);
    @(negedge clk);
    stat_sel = 5'(line);
    #2;
    c = stat_count;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // Checks the masked vector, the count and irq_out against the expected mask.
  task automatic check_view(input string tag, input logic [31:0] exp_act);
    logic [31:0] d;
    logic irq;
    do_read(6'h04, d, irq);
    check({tag, " R3 masked vector"}, d, exp_act);
    check({tag, " R7 irq_out"}, {31'd0, irq}, {31'd0, |exp_act});
    do_read(6'h00, d, irq);
    check({tag, " R2 active count"}, d, $countones(exp_act));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lines, en, seed, m1, m2, snap;
    logic irq;
    logic [15:0] c0, c1, h0, h1;
    rst_n = 0; irq_in = '0; bus_valid = 0; bus_write = 0;
    bus_addr = '0; bus_wdata = '0; stat_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R8: reset state
    check("R8 irq_out after reset", {31'd0, irq_out}, 32'd0);
    check_view("R8 reset", 32'd0);
    for (int i = 0; i < N; i++) begin
      read_cnt(i, c0);
      check("R8 counter after reset", {16'd0, c0}, 32'd0);
    end

    // R1 R5: each line alone, set then clear its enable bit
    for (int i = 0; i < N; i++) begin
      set_lines(32'd1 << i);
      do_write(6'h10, 32'd1 << i);
      check_view("R1 R5 single set", 32'd1 << i);
      do_write(6'h0C, 32'd1 << i);
      check_view("R1 R5 single clear", 32'd0);
    end

    // R2 R3 R6: pseudo-random lines with mixed set and clear masks
    en = '0;
    seed = 32'h1234_5678;
    for (int k = 0; k < 60; k++) begin
      seed = xs(seed); lines = seed;
      seed = xs(seed); m1 = seed;
      seed = xs(seed); m2 = seed & xs(seed);
      set_lines(lines);
      do_write(6'h10, m1);
      do_write(6'h0C, m2);
      en = (en | m1) & ~m2;
      check_view("R2 R3 R6 pattern", lines & en);
    end

    // R6: a line dropped low leaves pending
    do_write(6'h10, 32'hFFFF_FFFF);
    set_lines(32'h0000_00F0);
    check_view("R6 level high", 32'h0000_00F0);
    set_lines(32'h0000_0010);
    check_view("R6 level drop", 32'h0000_0010);

    // R9: unmapped and opposite-direction accesses
    set_lines(32'hA5A5_0F0F);
    do_write(6'h0C, 32'hFFFF_FFFF);
    do_write(6'h10, 32'h00FF_00FF);
    snap = 32'hA5A5_0F0F & 32'h00FF_00FF;
    for (int a = 0; a < 64; a++) begin
      if (a != 0 && a != 4) begin
        do_read(6'(a), d, irq);
        check("R9 unmapped read", d, 32'd0);
      end
    end
    do_write(6'h14, 32'hFFFF_FFFF);
    do_write(6'h20, 32'hFFFF_FFFF);
    do_write(6'h11, 32'hFFFF_FFFF);
    do_write(6'h0D, 32'hFFFF_FFFF);
    do_write(6'h09, 32'h0);
    do_write(6'h00, 32'hFFFF_FFFF);
    do_write(6'h04, 32'h0000_0000);
    check_view("R9 ignored writes", snap);

    // R4: wipe with zero data while enabled lines are active
    do_write(6'h08, 32'h0);
    check("R4 irq_out after wipe", {31'd0, irq_out}, 32'd0);
    check_view("R4 after wipe", 32'd0);
    do_write(6'h10, 32'h0000_0F00);
    check_view("R4 enables rebuilt", 32'hA5A5_0F0F & 32'h0000_0F00);

    // R10: pulses versus a held level
    set_lines(32'd0);
    do_write(6'h08, 32'hFFFF_FFFF);
    read_cnt(5, c0);
    read_cnt(7, h0);
    for (int p = 0; p < 3; p++) begin
      set_lines(32'd1 << 5);
      set_lines(32'd0);
    end
    set_lines(32'd1 << 7);
    repeat (10) @(negedge clk);
    set_lines(32'd0);
    @(negedge clk);
    read_cnt(5, c1);
    read_cnt(7, h1);
    check("R10 pulsed line count", {16'd0, 16'(c1 - c0)}, 32'd3);
    check("R10 held line count", {16'd0, 16'(h1 - h0)}, 32'd1);

    // R8: reset in the middle of activity
    set_lines(32'hFFFF_0000);
    do_write(6'h10, 32'hFFFF_FFFF);
    set_lines(32'd0);
    apply_reset();
    check("R8 irq_out after mid reset", {31'd0, irq_out}, 32'd0);
    for (int i = 0; i < N; i++) begin
      read_cnt(i, c0);
      check("R8 counter after mid reset", {16'd0, c0}, 32'd0);
    end
    set_lines(32'hFFFF_FFFF);
    check_view("R8 enables cleared", 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule